// File: doc/BRIEF.md
# RAM Controller Interrupt Register Block

This block is the small control and status register file that sits beside an on-chip RAM controller. It gathers hardware error events into an 11-bit sticky status word, lets software mask each source, and drives one registered, level-sensitive interrupt line. Software reaches it through a plain 32-bit register bus: an address, a write strobe, write data, and a read data port that returns the selected register in the same cycle. Every access is one aligned 32-bit word, and byte order is little-endian.

Software cannot write the mask directly. It clears mask bits through a write-only unmask register and sets them through a write-only mask-set register. In each case a 1 in the written data selects the bit and a 0 leaves it alone. The block also holds a 4-bit error-control register, and a read-only information register that reports the configured RAM size as a code. The size comes from a module parameter, and any size without a code stops elaboration.

Register offsets, in bytes: error control 0x00, status 0x04, mask 0x08, unmask 0x0C, mask-set 0x10, information 0x14. Bit i of the status, mask, unmask and mask-set registers belongs to event source i (event input bit i).

Top module: `ramc_irq_regs`

## Requirements
- R1: After reset, status reads 0x000, mask reads 0x7FF, error control reads 0xF, the unmask and mask-set offsets read 0, and the interrupt output is low.
- R2: A 1 on event input bit i at a clock edge sets status bit i. The bit then stays set until software clears it.
- R3: Writing the status offset clears each status bit whose data bit is 1 and leaves every other bit unchanged. Status bits 31:11 always read 0.
- R4: If an event and a software clear hit the same status bit in the same cycle, the event wins and the bit stays set.
- R5: The mask changes only through the unmask and mask-set offsets. A write to the mask offset has no effect.
- R6: Writing the unmask offset clears each mask bit whose data bit is 1. The unmask offset reads 0.
- R7: Writing the mask-set offset sets each mask bit whose data bit is 1. The mask-set offset reads 0.
- R8: The interrupt output is high exactly when, at the previous clock edge, some status bit was 1 and its mask bit was 0. The output therefore lags the status or mask change that causes it by one clock.
- R9: Error control stores write-data bits 3:0. Bits 31:4 read 0.
- R10: The information register reads the size code in bits 3:0: 0 = 64 KiB, 1 = 128 KiB, 2 = 256 KiB, 3 = 512 KiB, 4 = 1 MiB. The default is 1 MiB. Any other size fails elaboration.
- R11: An access to an offset that is unmapped, or that is not a multiple of 4, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_i | input | NSRC | Hardware event pulses, one per status bit |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench builds the block twice. The first instance keeps the default size of 1 MiB. With it, the bench drives events, clears, mask changes, a clear that collides with an event, and accesses to unmapped or misaligned offsets, and it times the interrupt cycle by cycle. The second instance is built at 64 KiB and only has its reset state read back. Comparing the two confirms that the size code follows the parameter and does not come from a fixed constant, covering both ends of the code range.

// File: rtl/ramc_regs_pkg.sv
package ramc_regs_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned CODE_W = 4;

  // byte offsets of the mapped words
  localparam int unsigned OFS_ERRCTL  = 'h00;
  localparam int unsigned OFS_STATUS  = 'h04;
  localparam int unsigned OFS_MASK    = 'h08;
  localparam int unsigned OFS_UNMASK  = 'h0C;
  localparam int unsigned OFS_MASKSET = 'h10;
  localparam int unsigned OFS_INFO    = 'h14;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_ERRCTL,
    RSEL_STATUS,
    RSEL_MASK,
    RSEL_UNMASK,
    RSEL_MASKSET,
    RSEL_INFO
  } rsel_e;

  localparam logic [CODE_W-1:0] CODE_BAD = '1;

  // RAM size in KiB -> information code; CODE_BAD for unsupported sizes
  function automatic logic [CODE_W-1:0] size_code(input int unsigned kib);
    case (kib)
      64:      return 4'd0;
      128:     return 4'd1;
      256:     return 4'd2;
      512:     return 4'd3;
      1024:    return 4'd4;
      default: return CODE_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ramc_reg_decode.sv
module ramc_reg_decode
  import ramc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output rsel_e             sel
);

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = RSEL_NONE;
    if (aligned) begin
      if      (addr == ADDR_W'(OFS_ERRCTL))  sel = RSEL_ERRCTL;
      else if (addr == ADDR_W'(OFS_STATUS))  sel = RSEL_STATUS;
      else if (addr == ADDR_W'(OFS_MASK))    sel = RSEL_MASK;
      else if (addr == ADDR_W'(OFS_UNMASK))  sel = RSEL_UNMASK;
      else if (addr == ADDR_W'(OFS_MASKSET)) sel = RSEL_MASKSET;
      else if (addr == ADDR_W'(OFS_INFO))    sel = RSEL_INFO;
    end
  end

endmodule

// File: rtl/ramc_irq_core.sv
module ramc_irq_core #(
  parameter int unsigned NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] wdata,
  input  logic            wr_clr,
  input  logic            wr_unmask,
  input  logic            wr_maskset,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);

  localparam logic [NSRC-1:0] MASK_RST = '1;

  // one sticky source: an event has priority over a clear in the same cycle
  function automatic logic src_next(input logic cur, input logic ev, input logic clr);
    return ev | (cur & ~clr);
  endfunction

  function automatic logic [NSRC-1:0] mask_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] setb,
                                                input logic [NSRC-1:0] clrb);
    return (cur & ~clrb) | setb;
  endfunction

  function automatic logic pending(input logic [NSRC-1:0] st, input logic [NSRC-1:0] mk);
    return |(st & ~mk);
  endfunction

  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] mset_bits;
  logic [NSRC-1:0] mclr_bits;

  assign clr_bits  = wr_clr     ? wdata : '0;
  assign mset_bits = wr_maskset ? wdata : '0;
  assign mclr_bits = wr_unmask  ? wdata : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= src_next(status_q[i], evt[i], clr_bits[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_RST;
    else        mask_q <= mask_next(mask_q, mset_bits, mclr_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending(status_q, mask_q);
  end

endmodule

// File: rtl/ramc_rd_mux.sv
module ramc_rd_mux
  import ramc_regs_pkg::*;
#(
  parameter int unsigned NSRC  = 11,
  parameter int unsigned ERR_W = 4
) (
  input  rsel_e              sel,
  input  logic [NSRC-1:0]    status,
  input  logic [NSRC-1:0]    mask,
  input  logic [ERR_W-1:0]   errctl,
  input  logic [CODE_W-1:0]  info,
  output logic [BUS_W-1:0]   rdata
);

  always_comb begin
    case (sel)
      RSEL_ERRCTL: rdata = BUS_W'(errctl);
      RSEL_STATUS: rdata = BUS_W'(status);
      RSEL_MASK:   rdata = BUS_W'(mask);
      RSEL_INFO:   rdata = BUS_W'(info);
      default:     rdata = '0;   // write-only words and unmapped space
    endcase
  end

endmodule

// File: rtl/ramc_irq_regs.sv
module ramc_irq_regs
  import ramc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NSRC    = 11,
  parameter int unsigned ERR_W   = 4,
  parameter int unsigned RAM_KIB = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSRC-1:0]   evt_i,
  output logic              irq_o
);

  localparam logic [CODE_W-1:0] SIZE_CODE = size_code(RAM_KIB);
  localparam logic [ERR_W-1:0]  ERR_RST   = '1;

  if (SIZE_CODE == CODE_BAD) begin : g_bad_size
    $error("ramc_irq_regs: RAM_KIB=%0d has no size code", RAM_KIB);
  end
  if (NSRC > BUS_W || ERR_W > BUS_W || ADDR_W < 5) begin : g_bad_width
    $error("ramc_irq_regs: width parameters out of range");
  end

  rsel_e            sel;
  logic             wr_status;
  logic             wr_unmask;
  logic             wr_maskset;
  logic             wr_errctl;
  logic [NSRC-1:0]  status_q;
  logic [NSRC-1:0]  mask_q;
  logic [ERR_W-1:0] errctl_q;

  ramc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  assign wr_status  = reg_wr && (sel == RSEL_STATUS);
  assign wr_unmask  = reg_wr && (sel == RSEL_UNMASK);
  assign wr_maskset = reg_wr && (sel == RSEL_MASKSET);
  assign wr_errctl  = reg_wr && (sel == RSEL_ERRCTL);

  ramc_irq_core #(.NSRC(NSRC)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_i),
    .wdata      (reg_wdata[NSRC-1:0]),
    .wr_clr     (wr_status),
    .wr_unmask  (wr_unmask),
    .wr_maskset (wr_maskset),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .irq_q      (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         errctl_q <= ERR_RST;
    else if (wr_errctl) errctl_q <= reg_wdata[ERR_W-1:0];
  end

  ramc_rd_mux #(.NSRC(NSRC), .ERR_W(ERR_W)) u_rd (
    .sel    (sel),
    .status (status_q),
    .mask   (mask_q),
    .errctl (errctl_q),
    .info   (SIZE_CODE),
    .rdata  (reg_rdata)
  );

endmodule

// File: rtl/ramc_irq_regs_chk.sv
module ramc_irq_regs_chk #(
  parameter int unsigned NSRC = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt,
  input logic [NSRC-1:0] wdata,
  input logic            wr_status,
  input logic            wr_unmask,
  input logic            wr_maskset,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] mask,
  input logic            irq
);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  p_status_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && !wr_status) |=> $stable(status));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && ((wdata & ~evt) != '0)) |=> ((status & $past(wdata & ~evt)) == '0));

  p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && ((wdata & evt) != '0)) |=> ((status & $past(wdata & evt)) == $past(wdata & evt)));

  p_mask_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_unmask || wr_maskset) |=> $stable(mask));

  p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask & $past(wdata)) == '0));

  p_maskset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_maskset |=> ((mask & $past(wdata)) == $past(wdata)));

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past((status & ~mask) != '0)));

endmodule

bind ramc_irq_regs ramc_irq_regs_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt        (evt_i),
  .wdata      (reg_wdata[NSRC-1:0]),
  .wr_status  (wr_status),
  .wr_unmask  (wr_unmask),
  .wr_maskset (wr_maskset),
  .status     (status_q),
  .mask       (mask_q),
  .irq        (irq_o)
);

// File: tb/ramc_irq_regs_test.sv
module ramc_irq_regs_test;

  localparam logic [7:0] A_ERR  = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_MASK = 8'h08;
  localparam logic [7:0] A_UNM  = 8'h0C;
  localparam logic [7:0] A_MSET = 8'h10;
  localparam logic [7:0] A_INFO = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_i = '0;
  logic        irq_o;
  logic [31:0] rdata_small;
  logic        irq_small;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ramc_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  ramc_irq_regs #(.RAM_KIB(64)) uut_small (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(1'b0),
    .reg_wdata(32'h0), .reg_rdata(rdata_small), .evt_i(11'h0), .irq_o(irq_small)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    rd(A_STAT, d); check("R1", "status", d, 32'h0);
    rd(A_MASK, d); check("R1", "mask", d, 32'h7FF);
    rd(A_ERR,  d); check("R1", "errctl", d, 32'hF);
    rd(A_UNM,  d); check("R1", "unmask read", d, 32'h0);
    rd(A_MSET, d); check("R1", "maskset read", d, 32'h0);
    check("R1", "irq", {31'h0, irq_o}, 32'h0);
    rd(A_INFO, d); check("R10", "info 1MiB", d, 32'h4);
    check("R10", "info 64KiB", rdata_small, 32'h0);
    check("R1", "irq small", {31'h0, irq_small}, 32'h0);
  endtask

  task automatic t_event;
    logic [31:0] d;
    pulse(11'h005);
    rd(A_STAT, d); check("R2", "status after event", d, 32'h005);
    @(negedge clk);
    rd(A_STAT, d); check("R2", "status held", d, 32'h005);
    check("R8", "masked source no irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(A_STAT, 32'hFFFF_FFF1);
    rd(A_STAT, d); check("R3", "clear bit0 only", d, 32'h004);
    wr(A_STAT, 32'h0000_0004);
    rd(A_STAT, d); check("R3", "clear bit2", d, 32'h000);
    pulse(11'h7FF);
    rd(A_STAT, d); check("R3", "upper bits zero", d, 32'h7FF);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R3", "clear all", d, 32'h000);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(A_MASK, 32'h0);
    rd(A_MASK, d); check("R5", "direct mask write ignored", d, 32'h7FF);
    wr(A_UNM, 32'h0F0);
    rd(A_MASK, d); check("R6", "unmask clears", d, 32'h70F);
    rd(A_UNM, d);  check("R6", "unmask reads zero", d, 32'h0);
    wr(A_MSET, 32'h010);
    rd(A_MASK, d); check("R7", "maskset sets", d, 32'h71F);
    rd(A_MSET, d); check("R7", "maskset reads zero", d, 32'h0);
  endtask

  task automatic t_irq;
    pulse(11'h020);
    check("R8", "irq lags event", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R8", "irq rises", {31'h0, irq_o}, 32'h1);
    wr(A_MSET, 32'h020);
    check("R8", "irq lags mask", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    check("R8", "irq masked", {31'h0, irq_o}, 32'h0);
    wr(A_UNM, 32'h020);
    check("R8", "irq lags unmask", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R8", "irq back", {31'h0, irq_o}, 32'h1);
    wr(A_STAT, 32'h020);
    check("R8", "irq lags clear", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    check("R8", "irq cleared", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    pulse(11'h002);
    @(negedge clk);
    evt_i = 11'h008; reg_addr = A_STAT; reg_wdata = 32'h00A; reg_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0;
    rd(A_STAT, d); check("R4", "event beats clear", d, 32'h008);
    wr(A_STAT, 32'h008);
    rd(A_STAT, d); check("R4", "later clear works", d, 32'h000);
  endtask

  task automatic t_errctl;
    logic [31:0] d;
    wr(A_ERR, 32'hFFFF_FFF5);
    rd(A_ERR, d); check("R9", "errctl 4 bits", d, 32'h5);
    wr(A_ERR, 32'h0);
    rd(A_ERR, d); check("R9", "errctl zero", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    pulse(11'h400);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R11", "misaligned clear ignored", d, 32'h400);
    rd(8'h05, d);  check("R11", "misaligned read zero", d, 32'h0);
    wr(8'h0D, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R11", "misaligned unmask ignored", d, 32'h71F);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(A_ERR, d);  check("R11", "misaligned errctl ignored", d, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d);  check("R11", "unmapped read zero", d, 32'h0);
    rd(8'hFC, d);  check("R11", "high unmapped read zero", d, 32'h0);
    rd(A_STAT, d); check("R11", "status after unmapped", d, 32'h400);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_event;
    t_w1c;
    t_mask;
    t_irq;
    t_collide;
    t_errctl;
    t_unmapped;
    finished = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      summary;
      $finish;
    end
  end

endmodule